// File: doc/BRIEF.md
# Processor Condition Code Generator

This unit turns the outcome of an integer instruction into a two-bit condition code. An operation selector picks one of fifteen rules. The unit applies that rule to three 64-bit inputs: the first operand, the second operand and the result the datapath produced. A width input picks either the full 64 bits or only the low 32 bits of each input. In 32-bit mode those bits are read as signed or unsigned, as the selected rule requires.

The rules cover signed and unsigned compare, signed and unsigned add and subtract, absolute value, complement, a nonzero test, test-under-mask, insert-characters-under-mask and four constant codes. The rules differ in how they treat overflow, carry, borrow, mixed mask bits and the most negative value. The selector value 15 is not defined. For that value the unit drives code 0 and raises an error flag. By default the code and the flag pass through one output register, so each set of inputs is answered one clock later.

Top module: `ccode_gen`

## Requirements
- R1: Selectors 4 (signed compare) and 5 (unsigned compare) give 0 when opa equals opb, 1 when opa is below opb and 2 when opa is above opb.
- R2: Selector 8 (signed add) gives 3 when opa and opb have the same sign bit and res has the other sign bit. Otherwise it gives 0 for a zero res, 1 for a negative res and 2 for a positive res.
- R3: Selector 10 (signed subtract) gives 3 when opa and opb have different sign bits and the sign of res differs from the sign of opa. Otherwise it follows the sign of res, as in R2.
- R4: Selector 9 (unsigned add) with a zero res gives 2 if opa is nonzero and 0 if opa is zero. With a nonzero res it gives 3 when res is below opa or below opb (a carry), and 1 otherwise.
- R5: Selector 11 (unsigned subtract) gives 2 for a zero res. Otherwise it gives 1 when opb exceeds opa (a borrow) and 3 when opb does not exceed opa.
- R6: Selector 6 (test-under-mask) takes its mask from opb[15:0] and its value from opa[15:0]. It gives 0 when the mask is empty or every selected bit is 0, and 3 when every selected bit is 1. For mixed bits it gives 2 when the value bit at the highest set mask bit is 1, and 1 when that bit is 0. Width has no effect.
- R7: Selector 12 (absolute value) gives 3 when res is the most negative value of the selected width, 1 for any other nonzero res and 0 for zero.
- R8: Selector 13 (complement) gives 3 when res is the most negative value of the selected width. Otherwise it gives 1 for a negative res, 2 for a positive res and 0 for zero.
- R9: Selector 14 (insert under mask) takes its mask from opb[3:0] and its value from res[31:0]. Mask bit k stands for bits 8k+7..8k. It gives 0 for an empty mask or a zero value. With the full mask 4'hF it gives 1 when bit 31 is set and 2 otherwise. For any other mask it gives 1 or 2 from bit 8k+7, where k is the highest set mask bit. Width has no effect.
- R10: Selectors 0 to 3 give their own value as the code. Selector 7 (nonzero test) gives 1 for a nonzero res and 0 for a zero res.
- R11: When wide is 0, bits 63:32 of opa, opb and res have no effect on any code. The low 32 bits are then read as a 32-bit signed or unsigned value.
- R12: Selector 15 gives code 0 and sets bad_op for that one answer only. Every defined selector answers with bad_op at 0.
- R13: While rst_n is low, cc and bad_op are 0. Otherwise cc and bad_op show the answer to the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset, synchronous |
| sel | input | 4 | Operation selector (0..15) |
| wide | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand; also the mask for selectors 6 and 14 |
| res | input | 64 | Result of the operation |
| cc | output | 2 | Condition code |
| bad_op | output | 1 | Set for an undefined selector |

## Verification
Two rules can both apply to one answer: the overflow test and the sign-of-result test in signed add and subtract, and the most-negative test and the sign test in complement. Directed cases give res the most negative value together with operands whose sign bits trigger or avoid overflow, in both widths. The bench accepts code 3 only when its own model says the special case wins. A second clash is an undefined selector following a defined one. The bench checks that bad_op rises for exactly that answer and that the code is 0 in the same cycle.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  typedef enum logic [3:0] {
    SEL_K0    = 4'd0,
    SEL_K1    = 4'd1,
    SEL_K2    = 4'd2,
    SEL_K3    = 4'd3,
    SEL_CMPS  = 4'd4,
    SEL_CMPU  = 4'd5,
    SEL_TMASK = 4'd6,
    SEL_NZ    = 4'd7,
    SEL_ADDS  = 4'd8,
    SEL_ADDU  = 4'd9,
    SEL_SUBS  = 4'd10,
    SEL_SUBU  = 4'd11,
    SEL_ABS   = 4'd12,
    SEL_COMP  = 4'd13,
    SEL_ICM   = 4'd14,
    SEL_RSVD  = 4'd15
  } ccg_sel_e;

  // 0 for zero, 1 for negative, 2 for positive
  function automatic logic [1:0] sign_code(input logic neg, input logic zero);
    if (zero)     return 2'd0;
    else if (neg) return 2'd1;
    else          return 2'd2;
  endfunction

  function automatic logic [1:0] order_code(input logic eq, input logic lt);
    if (eq)      return 2'd0;
    else if (lt) return 2'd1;
    else         return 2'd2;
  endfunction

  // Test-under-mask on a 16-bit mask
  function automatic logic [1:0] tmask_code(input logic [15:0] val, input logic [15:0] msk);
    logic [15:0] hit;
    logic        lead;
    hit  = val & msk;
    lead = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (msk[i]) lead = val[i];
    end
    if (msk == 16'd0 || hit == 16'd0) return 2'd0;
    else if (hit == msk)              return 2'd3;
    else if (lead)                    return 2'd2;
    else                              return 2'd1;
  endfunction

  // Insert-under-mask: mask bit k covers byte k of the 32-bit value
  function automatic logic [1:0] icm_code(input logic [3:0] msk, input logic [31:0] val);
    logic top;
    top = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (msk[k]) top = val[8*k+7];
    end
    if (msk == 4'd0 || val == 32'd0) return 2'd0;
    else if (top)                    return 2'd1;
    else                             return 2'd2;
  endfunction

endpackage

// File: rtl/ccg_prep.sv
// Narrows one operand to the selected width in two forms: sign- and zero-extended.
module ccg_prep #(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic [DW-1:0] raw,
  input  logic          wide,
  output logic [DW-1:0] sx,
  output logic [DW-1:0] zx
);
  localparam int PAD = DW - HW;

  always_comb begin
    if (wide) begin
      sx = raw;
      zx = raw;
    end else begin
      sx = {{PAD{raw[HW-1]}}, raw[HW-1:0]};
      zx = {{PAD{1'b0}},      raw[HW-1:0]};
    end
  end
endmodule

// File: rtl/ccg_eval.sv
module ccg_eval
  import ccg_pkg::*;
#(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic [3:0]    sel,
  input  logic          wide,
  input  logic [DW-1:0] sx_a,
  input  logic [DW-1:0] sx_b,
  input  logic [DW-1:0] sx_r,
  input  logic [DW-1:0] zx_a,
  input  logic [DW-1:0] zx_b,
  input  logic [DW-1:0] zx_r,
  output logic [1:0]    cc_nxt,
  output logic          err_nxt,
  output logic          add_ovf,
  output logic          mneg_r
);
  localparam int PAD = DW - HW;
  localparam logic [DW-1:0] MNEG_WIDE = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MNEG_HALF = {{(PAD+1){1'b1}}, {(HW-1){1'b0}}};

  logic neg_a, neg_b, neg_r;
  logic zero_a, zero_r;
  logic eq_ab, slt_ab, ult_ab;
  logic sub_ovf, carry, borrow;

  assign neg_a   = sx_a[DW-1];
  assign neg_b   = sx_b[DW-1];
  assign neg_r   = sx_r[DW-1];
  assign zero_a  = (zx_a == '0);
  assign zero_r  = (zx_r == '0);
  assign eq_ab   = (zx_a == zx_b);
  assign slt_ab  = ($signed(sx_a) < $signed(sx_b));
  assign ult_ab  = (zx_a < zx_b);
  assign add_ovf = (neg_a == neg_b) && (neg_r != neg_a);
  assign sub_ovf = (neg_a != neg_b) && (neg_r != neg_a);
  assign carry   = (zx_r < zx_a) || (zx_r < zx_b);
  assign borrow  = (zx_b > zx_a);
  assign mneg_r  = wide ? (sx_r == MNEG_WIDE) : (sx_r == MNEG_HALF);

  always_comb begin
    err_nxt = 1'b0;
    cc_nxt  = 2'd0;
    unique case (ccg_sel_e'(sel))
      SEL_K0, SEL_K1, SEL_K2, SEL_K3: cc_nxt = sel[1:0];
      SEL_CMPS:  cc_nxt = order_code(eq_ab, slt_ab);
      SEL_CMPU:  cc_nxt = order_code(eq_ab, ult_ab);
      SEL_TMASK: cc_nxt = tmask_code(zx_a[15:0], zx_b[15:0]);
      SEL_NZ:    cc_nxt = zero_r ? 2'd0 : 2'd1;
      SEL_ADDS:  cc_nxt = add_ovf ? 2'd3 : sign_code(neg_r, zero_r);
      SEL_SUBS:  cc_nxt = sub_ovf ? 2'd3 : sign_code(neg_r, zero_r);
      SEL_ADDU: begin
        if (zero_r) cc_nxt = zero_a ? 2'd0 : 2'd2;
        else        cc_nxt = carry  ? 2'd3 : 2'd1;
      end
      SEL_SUBU: begin
        if (zero_r) cc_nxt = 2'd2;
        else        cc_nxt = borrow ? 2'd1 : 2'd3;
      end
      SEL_ABS:   cc_nxt = mneg_r ? 2'd3 : (zero_r ? 2'd0 : 2'd1);
      SEL_COMP:  cc_nxt = mneg_r ? 2'd3 : sign_code(neg_r, zero_r);
      SEL_ICM:   cc_nxt = icm_code(zx_b[3:0], zx_r[31:0]);
      SEL_RSVD:  err_nxt = 1'b1;
      default:   err_nxt = 1'b1;
    endcase
  end
endmodule

// File: rtl/ccg_stage.sv
// Optional output register; REG_OUT = 0 gives a plain wire.
module ccg_stage #(
  parameter int W       = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_flop
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
      end
      assign q = q_r;
    end else begin : g_wire
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/ccode_gen.sv
module ccode_gen #(
  parameter int DW      = 64,
  parameter int HW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    sel,
  input  logic          wide,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] res,
  output logic [1:0]    cc,
  output logic          bad_op
);
  localparam int NOPS = 3;

  logic [DW-1:0] raw_v [NOPS];
  logic [DW-1:0] sx_v  [NOPS];
  logic [DW-1:0] zx_v  [NOPS];

  assign raw_v[0] = opa;
  assign raw_v[1] = opb;
  assign raw_v[2] = res;

  generate
    for (genvar g = 0; g < NOPS; g++) begin : g_prep
      ccg_prep #(.DW(DW), .HW(HW)) u_prep (
        .raw (raw_v[g]),
        .wide(wide),
        .sx  (sx_v[g]),
        .zx  (zx_v[g])
      );
    end
  endgenerate

  // Named internal events, observed by the checker
  logic [1:0] cc_nxt;
  logic       err_nxt;
  logic       ovf_s;
  logic       mneg_r;

  ccg_eval #(.DW(DW), .HW(HW)) u_eval (
    .sel    (sel),
    .wide   (wide),
    .sx_a   (sx_v[0]),
    .sx_b   (sx_v[1]),
    .sx_r   (sx_v[2]),
    .zx_a   (zx_v[0]),
    .zx_b   (zx_v[1]),
    .zx_r   (zx_v[2]),
    .cc_nxt (cc_nxt),
    .err_nxt(err_nxt),
    .add_ovf(ovf_s),
    .mneg_r (mneg_r)
  );

  logic [2:0] out_q;

  ccg_stage #(.W(3), .REG_OUT(REG_OUT)) u_stage (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({err_nxt, cc_nxt}),
    .q    (out_q)
  );

  assign cc     = out_q[1:0];
  assign bad_op = out_q[2];
endmodule

// File: rtl/ccode_gen_chk.sv
module ccode_gen_chk #(
  parameter int DW      = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    sel,
  input logic          wide,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic [DW-1:0] res,
  input logic [1:0]    cc,
  input logic          bad_op,
  input logic [1:0]    cc_nxt,
  input logic          err_nxt,
  input logic          ovf_s,
  input logic          mneg_r
);
  localparam logic [DW-1:0] MIN_W = {1'b1, {(DW-1){1'b0}}};

  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  logic ops_eq, res_mneg;
  assign ops_eq   = wide ? (opa == opb) : (opa[31:0] == opb[31:0]);
  assign res_mneg = wide ? (res == MIN_W) : (res[31:0] == 32'h8000_0000);

  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == 4'd4 || sel == 4'd5) && ops_eq) |-> (cc_nxt == 2'd0)); // R1

  AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'd8 && ovf_s) |-> (cc_nxt == 2'd3)); // R2

  AST_SUBU_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'd11 && (wide ? res == '0 : res[31:0] == 32'd0)) |-> (cc_nxt == 2'd2)); // R5

  AST_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == 4'd12 || sel == 4'd13) && res_mneg) |-> (mneg_r && cc_nxt == 2'd3)); // R8

  AST_CONST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[3:2] == 2'b00) |-> (cc_nxt == sel[1:0] && !err_nxt)); // R10

  AST_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    err_nxt |-> (sel == 4'd15 && cc_nxt == 2'd0)); // R12

  generate
    if (REG_OUT) begin : g_lat
      AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (cc == $past(cc_nxt) && bad_op == $past(err_nxt))); // R13
    end
  endgenerate
endmodule

bind ccode_gen ccode_gen_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sel    (sel),
  .wide   (wide),
  .opa    (opa),
  .opb    (opb),
  .res    (res),
  .cc     (cc),
  .bad_op (bad_op),
  .cc_nxt (cc_nxt),
  .err_nxt(err_nxt),
  .ovf_s  (ovf_s),
  .mneg_r (mneg_r)
);

// File: tb/ccode_gen_bench.sv
`timescale 1ns/1ps
module ccode_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel = '0;
  logic        wide = 1'b0;
  logic [63:0] opa = '0, opb = '0, res = '0;
  logic [1:0]  cc;
  logic        bad_op;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  ccode_gen u_ccode_gen (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wide(wide),
    .opa(opa), .opb(opb), .res(res), .cc(cc), .bad_op(bad_op)
  );

  // Behavioural reference model
  function automatic void model(input logic [3:0] s, input bit w,
                                input logic [63:0] a, b, r,
                                output logic [1:0] c, output bit e, output string t);
    longint unsigned ua, ub, ur;
    longint sa, sb, sr;
    bit mn;
    int hi;
    ua = w ? a : {32'd0, a[31:0]};
    ub = w ? b : {32'd0, b[31:0]};
    ur = w ? r : {32'd0, r[31:0]};
    sa = w ? longint'(a) : longint'(int'(a[31:0]));
    sb = w ? longint'(b) : longint'(int'(b[31:0]));
    sr = w ? longint'(r) : longint'(int'(r[31:0]));
    mn = w ? (r == 64'h8000_0000_0000_0000) : (r[31:0] == 32'h8000_0000);
    e = 0; c = 0;
    case (s)
      0, 1, 2, 3: begin c = s[1:0]; t = "R10"; end
      4: begin t = "R1"; c = (sa == sb) ? 0 : (sa < sb) ? 1 : 2; end
      5: begin t = "R1"; c = (ua == ub) ? 0 : (ua < ub) ? 1 : 2; end
      6: begin
        t = "R6"; hi = -1;
        for (int i = 0; i < 16; i++) if (b[i]) hi = i;
        if (b[15:0] == 0 || (a[15:0] & b[15:0]) == 0) c = 0;
        else if ((a[15:0] & b[15:0]) == b[15:0]) c = 3;
        else c = a[hi] ? 2 : 1;
      end
      7: begin t = "R10"; c = (ur != 0) ? 1 : 0; end
      8: begin
        t = "R2";
        if (((sa < 0) == (sb < 0)) && ((sr < 0) != (sa < 0))) c = 3;
        else c = (sr == 0) ? 0 : (sr < 0) ? 1 : 2;
      end
      9: begin
        t = "R4";
        if (ur == 0) c = (ua != 0) ? 2 : 0;
        else c = (ur < ua || ur < ub) ? 3 : 1;
      end
      10: begin
        t = "R3";
        if (((sa < 0) != (sb < 0)) && ((sr < 0) != (sa < 0))) c = 3;
        else c = (sr == 0) ? 0 : (sr < 0) ? 1 : 2;
      end
      11: begin t = "R5"; c = (ur == 0) ? 2 : (ub > ua) ? 1 : 3; end
      12: begin t = "R7"; c = mn ? 3 : (ur != 0) ? 1 : 0; end
      13: begin t = "R8"; c = mn ? 3 : (sr == 0) ? 0 : (sr < 0) ? 1 : 2; end
      14: begin
        t = "R9"; hi = -1;
        for (int k = 0; k < 4; k++) if (b[k]) hi = k;
        if (b[3:0] == 0 || r[31:0] == 0) c = 0;
        else c = r[8*hi+7] ? 1 : 2;
      end
      default: begin t = "R12"; c = 0; e = 1; end
    endcase
  endfunction

  logic [1:0] exp_cc;
  bit         exp_err;
  string      exp_tag;
  bit         pend = 0;

  task automatic check_out(input logic [1:0] ec, input bit ee, input string tg);
    n_chk++;
    if (cc !== ec) begin
      n_bad++;
      $display("FAIL %s cc actual=%0d expected=%0d", tg, cc, ec);
    end
    if (bad_op !== ee) begin
      n_bad++;
      $display("FAIL R12 bad_op actual=%0b expected=%0b (%s)", bad_op, ee, tg);
    end
  endtask

  // Checks the previous answer, then drives a new set of inputs
  task automatic step(input logic [3:0] s, input bit w, input logic [63:0] a, b, r);
    @(negedge clk);
    if (pend) check_out(exp_cc, exp_err, exp_tag);
    sel = s; wide = w; opa = a; opb = b; res = r;
    model(s, w, a, b, r, exp_cc, exp_err, exp_tag);
    pend = 1;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 7))
      0: return 64'd0;
      1: return 64'h8000_0000_0000_0000;
      2: return {$urandom, 32'h8000_0000};
      3: return '1;
      4: return {$urandom, 32'h7FFF_FFFF};
      5: return 64'h7FFF_FFFF_FFFF_FFFF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [63:0] MINW = 64'h8000_0000_0000_0000;

  initial begin
    sel = 4'd3; wide = 1; opa = '1; opb = '1; res = '1;
    repeat (3) @(negedge clk);
    check_out(2'd0, 1'b0, "R13"); // reset state
    rst_n = 1'b1;
    // R10 constants and nonzero
    for (int k = 0; k < 4; k++) step(4'(k), 1, '1, '1, '1);
    step(7, 1, 0, 0, 0);
    step(7, 0, 0, 0, 64'hFFFF_FFFF_0000_0000); // R11: high half ignored
    step(7, 1, 0, 0, 64'h1_0000_0000);
    // R1 compares
    step(4, 1, 5, 5, 0);
    step(4, 1, '1, 1, 0);
    step(5, 1, '1, 1, 0);
    step(4, 0, 64'h1_FFFF_FFFF, 64'h0_0000_0001, 0); // R11: -1 < 1
    step(5, 0, 64'hAAAA_0000_0007, 64'h5555_0000_0007, 0); // R11 equal
    // R2 signed add: overflow vs sign clash
    step(8, 1, 64'h7FFF_FFFF_FFFF_FFFF, 1, MINW);
    step(8, 0, 64'h7FFF_FFFF, 1, 64'h8000_0000);
    step(8, 1, MINW, MINW, 0);
    step(8, 1, 3, -64'sd5, -64'sd2);
    // R3 signed subtract
    step(10, 1, MINW, 1, 64'h7FFF_FFFF_FFFF_FFFF);
    step(10, 0, 64'h8000_0000, 1, 64'h7FFF_FFFF);
    step(10, 1, 9, 4, 5);
    step(10, 1, 4, 4, 0);
    // R4 unsigned add
    step(9, 1, 0, 0, 0);
    step(9, 1, 1, '1, 0);
    step(9, 1, '1, 2, 1);
    step(9, 0, 64'hFFFF_FFFF, 2, 64'h1_0000_0001);
    step(9, 1, 2, 3, 5);
    // R5 unsigned subtract
    step(11, 1, 7, 7, 0);
    step(11, 1, 3, 5, '1);
    step(11, 1, 5, 3, 2);
    // R6 test-under-mask
    step(6, 1, 64'hFFFF, 0, 0);
    step(6, 1, 64'h00F0, 64'h00F0, 0);
    step(6, 1, 64'h0010, 64'h00F0, 0);
    step(6, 1, 64'h0080, 64'h00F0, 0);
    step(6, 0, 64'h0000, 64'h8001, 0);
    // R7 / R8 most negative in both widths
    step(12, 1, 0, 0, MINW);
    step(12, 0, 0, 0, 64'h1234_5678_8000_0000);
    step(12, 1, 0, 0, 0);
    step(12, 1, 0, 0, '1);
    step(13, 1, 0, 0, MINW);
    step(13, 0, 0, 0, 64'h8000_0000);
    step(13, 1, 0, 0, MINW); // most negative wins over sign
    step(13, 1, 0, 0, 64'h8000_0000); // 64-bit: just positive
    step(13, 0, 0, 0, 64'hFFFF_FFFF);
    // R9 insert under mask
    step(14, 1, 0, 64'hF, 64'h8000_0000);
    step(14, 1, 0, 64'hF, 64'h7000_0000);
    step(14, 1, 0, 0, 64'hFFFF_FFFF);
    step(14, 1, 0, 64'h3, 0);
    step(14, 1, 0, 64'h3, 64'h0000_8000);
    step(14, 1, 0, 64'h5, 64'h0080_0000);
    step(14, 1, 0, 64'h1, 64'h0000_0001);
    // R12 undefined selector next to defined ones
    step(4, 1, 1, 1, 0);
    step(15, 1, '1, '1, '1);
    step(3, 1, 0, 0, 0);
    step(15, 0, 0, 0, 0);
    step(15, 1, 0, 0, 0);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] a, b, r;
      a = pick(); b = pick();
      case ($urandom_range(0, 2))
        0: r = a + b;
        1: r = a - b;
        default: r = pick();
      endcase
      step(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), a, b, r);
    end
    @(negedge clk);
    check_out(exp_cc, exp_err, exp_tag);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule